// File: doc/BRIEF.md
# Geometry Coprocessor Data Register File

This block holds the thirty-two 32-bit data registers of a fixed-point geometry coprocessor. Software reaches it through one register port: a 5-bit slot index, a write strobe with 32-bit write data, and a 32-bit read result that is combinational from the index. Many slots transform the data on the way in or out. Some slots widen a halfword with a sign or a zero. One slot pushes a three-deep screen-coordinate FIFO. One slot splits a packed 5:5:5 colour into three intermediate registers, and a read of that slot packs them back. One slot feeds a leading sign-bit counter whose result lands in a read-only neighbour.

A separate compute unit loads results through dedicated update ports: the four accumulators, the four intermediates, a push into the screen-XY FIFO and a push into the four-deep depth FIFO. Software has priority. On any cycle where the software write strobe is high, every compute update of that cycle is discarded.

Top module: `cop_dreg_file`

## Requirements
- R1: A write to slot 1, 3, 5, 8, 9, 10 or 11 stores bits 15:0 of the write data sign-extended to 32 bits.
- R2: A write to slot 7 or to slots 16 to 19 stores bits 15:0 of the write data zero-extended to 32 bits.
- R3: A write to slot 15 shifts the coordinate FIFO: slot 12 gets the old slot 13, slot 13 gets the old slot 14, and slot 14 gets the write data.
- R4: A read of slot 15 returns the current content of slot 14.
- R5: A write to slot 28 keeps write-data bits 14:0. It also loads slot 9 with bits 4:0 times 0x80, slot 10 with bits 9:5 times 0x80 and slot 11 with bits 14:10 times 0x80, each as a non-negative 32-bit value.
- R6: A read of slot 28 or 29 returns a 15-bit colour, zero above bit 14. Bits 4:0 come from slot 9, bits 9:5 from slot 10 and bits 14:10 from slot 11. Each field is the low halfword of its slot, taken as signed, divided by 0x80 with rounding toward zero, and clamped to 0..31. A negative value therefore gives 0.
- R7: A write to slot 30 stores the data unchanged. It also sets slot 31 to the number of leading bits that equal bit 31, a value from 1 to 32.
- R8: Writes to slot 29 and slot 31 change nothing.
- R9: Writes to slots 0, 2, 4, 6, 12, 13, 14 and 20 to 27 store the data unchanged, and reads return it.
- R10: Compute update ports act on the clock edge. Accumulator enable bit k writes data word k to slot 24+k. Intermediate enable bit k writes halfword k, sign-extended, to slot 8+k. An XY push shifts slots 12..14 as in R3 with the pushed word. A depth push moves slot 17 to 16, 18 to 17 and 19 to 18, and loads slot 19 with the zero-extended halfword.
- R11: On a cycle where the software write strobe is high, all compute updates of that cycle are discarded.
- R12: Synchronous active-high reset clears every slot to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_idx | input | 5 | Slot index for both read and write |
| reg_we | input | 1 | Software write strobe |
| reg_wdata | input | 32 | Software write data |
| reg_rdata | output | 32 | Combinational read result for reg_idx |
| upd_acc_we | input | 4 | Per-accumulator update enables (slots 24..27) |
| upd_acc_data | input | 128 | Accumulator words, word k in bits 32k+31:32k |
| upd_ir_we | input | 4 | Per-intermediate update enables (slots 8..11) |
| upd_ir_data | input | 64 | Intermediate halfwords, halfword k in bits 16k+15:16k |
| upd_xy_push | input | 1 | Push one word into the coordinate FIFO |
| upd_xy_data | input | 32 | Coordinate word to push |
| upd_z_push | input | 1 | Push one halfword into the depth FIFO |
| upd_z_data | input | 16 | Depth halfword to push |

## Verification
Every write effect is registered, so a write or compute update presented in one cycle is visible from the clock edge that ends that cycle. Read conversions (the slot-15 mirror and the colour packing) are purely combinational from the index and the stored state. The bench applies each write for exactly one cycle. It queues the expected read values only after the capturing edge has passed, and the monitor samples the read port two nanoseconds after a falling edge, when the index it drives has settled. Priority cases present a software write and compute updates in the same cycle. The slots the compute updates would have changed are then read back.

// File: rtl/cop_dreg_pkg.sv
package cop_dreg_pkg;

    localparam int unsigned DATA_W     = 32;
    localparam int unsigned HALF_W     = 16;
    localparam int unsigned SLOT_COUNT = 32;
    localparam int unsigned IDX_W      = $clog2(SLOT_COUNT);
    localparam int unsigned NUM_ACC    = 4;
    localparam int unsigned NUM_IR     = 4;
    localparam int unsigned NUM_CHAN   = 3;
    localparam int unsigned XY_DEPTH   = 3;
    localparam int unsigned Z_DEPTH    = 4;
    localparam int unsigned CFIELD_W   = 5;
    localparam int unsigned CSCALE_SH  = 7;
    localparam int unsigned CPACK_W    = CFIELD_W * NUM_CHAN;
    localparam int unsigned LEAD_CNT_W = $clog2(DATA_W + 1);

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [HALF_W-1:0] half_t;
    typedef logic [IDX_W-1:0]  idx_t;

    localparam idx_t S_VZ0     = idx_t'(1);
    localparam idx_t S_VZ1     = idx_t'(3);
    localparam idx_t S_VZ2     = idx_t'(5);
    localparam idx_t S_ORDZ    = idx_t'(7);
    localparam idx_t S_IR_BASE = idx_t'(8);
    localparam idx_t S_XY_BASE = idx_t'(12);
    localparam idx_t S_XY_PUSH = idx_t'(15);
    localparam idx_t S_Z_BASE  = idx_t'(16);
    localparam idx_t S_ACC0    = idx_t'(24);
    localparam idx_t S_CLR_IN  = idx_t'(28);
    localparam idx_t S_CLR_OUT = idx_t'(29);
    localparam idx_t S_LEAD_IN = idx_t'(30);
    localparam idx_t S_LEAD_CT = idx_t'(31);

    typedef enum logic [2:0] {
        WK_PLAIN,
        WK_SEXT,
        WK_ZEXT,
        WK_FIFO,
        WK_COLOUR,
        WK_LEAD,
        WK_RO
    } wr_kind_t;

    function automatic word_t sext_half(half_t h);
        return {{(DATA_W-HALF_W){h[HALF_W-1]}}, h};
    endfunction

    function automatic word_t zext_half(half_t h);
        return {{(DATA_W-HALF_W){1'b0}}, h};
    endfunction

    function automatic idx_t slot_at(idx_t base, int unsigned ofs);
        return idx_t'(int'(base) + int'(ofs));
    endfunction

    function automatic wr_kind_t wr_kind(idx_t i);
        wr_kind_t k;
        case (i)
            S_VZ0, S_VZ1, S_VZ2,
            idx_t'(8), idx_t'(9), idx_t'(10), idx_t'(11):    k = WK_SEXT;
            S_ORDZ,
            idx_t'(16), idx_t'(17), idx_t'(18), idx_t'(19):  k = WK_ZEXT;
            S_XY_PUSH:                                       k = WK_FIFO;
            S_CLR_IN:                                        k = WK_COLOUR;
            S_LEAD_IN:                                       k = WK_LEAD;
            S_CLR_OUT, S_LEAD_CT:                            k = WK_RO;
            default:                                         k = WK_PLAIN;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/cop_dreg_lead_count.sv
module cop_dreg_lead_count
    import cop_dreg_pkg::*;
#(
    parameter int unsigned W     = DATA_W,
    parameter int unsigned CNT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     value,
    output logic [CNT_W-1:0] count
);
    // run[i] is high while bits W-1 down to i all match the top bit
    logic [W-1:0] run;

    assign run[W-1] = 1'b1;

    generate
        for (genvar i = W - 2; i >= 0; i--) begin : g_run
            assign run[i] = run[i+1] & (value[i] == value[W-1]);
        end
    endgenerate

    always_comb begin
        count = '0;
        for (int i = 0; i < int'(W); i++) begin
            count = count + CNT_W'(run[i]);
        end
    end
endmodule

// File: rtl/cop_dreg_colour_pack.sv
module cop_dreg_colour_pack
    import cop_dreg_pkg::*;
#(
    parameter int unsigned NCH = NUM_CHAN,
    parameter int unsigned HW  = HALF_W,
    parameter int unsigned FW  = CFIELD_W,
    parameter int unsigned SH  = CSCALE_SH
) (
    input  logic [NCH*HW-1:0] ir_flat,
    output logic [NCH*FW-1:0] packed_out
);
    localparam int unsigned QW   = HW - 1 - SH;
    localparam int unsigned FMAX = (1 << FW) - 1;

    generate
        for (genvar c = 0; c < int'(NCH); c++) begin : g_chan
            logic [HW-1:0] ir;
            logic [QW-1:0] quo;
            assign ir  = ir_flat[c*HW +: HW];
            // positive values: quotient toward zero is a plain right shift
            assign quo = ir[HW-2:SH];
            always_comb begin
                if (ir[HW-1])
                    packed_out[c*FW +: FW] = '0;
                else if (quo > QW'(FMAX))
                    packed_out[c*FW +: FW] = FW'(FMAX);
                else
                    packed_out[c*FW +: FW] = quo[FW-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/cop_dreg_colour_unpack.sv
module cop_dreg_colour_unpack
    import cop_dreg_pkg::*;
#(
    parameter int unsigned NCH = NUM_CHAN,
    parameter int unsigned HW  = HALF_W,
    parameter int unsigned FW  = CFIELD_W,
    parameter int unsigned SH  = CSCALE_SH
) (
    input  logic [NCH*FW-1:0] fields,
    output logic [NCH*HW-1:0] ir_flat
);
    generate
        for (genvar c = 0; c < int'(NCH); c++) begin : g_chan
            assign ir_flat[c*HW +: HW] = {{(HW-FW-SH){1'b0}}, fields[c*FW +: FW], {SH{1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/cop_dreg_file.sv
module cop_dreg_file
    import cop_dreg_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [IDX_W-1:0]          reg_idx,
    input  logic                      reg_we,
    input  logic [DATA_W-1:0]         reg_wdata,
    output logic [DATA_W-1:0]         reg_rdata,
    input  logic [NUM_ACC-1:0]        upd_acc_we,
    input  logic [NUM_ACC*DATA_W-1:0] upd_acc_data,
    input  logic [NUM_IR-1:0]         upd_ir_we,
    input  logic [NUM_IR*HALF_W-1:0]  upd_ir_data,
    input  logic                      upd_xy_push,
    input  logic [DATA_W-1:0]         upd_xy_data,
    input  logic                      upd_z_push,
    input  logic [HALF_W-1:0]         upd_z_data
);
    word_t regs_q [SLOT_COUNT];
    word_t regs_d [SLOT_COUNT];

    logic [LEAD_CNT_W-1:0]      lead_cnt;
    logic [CPACK_W-1:0]         clr_packed;
    logic [NUM_CHAN*HALF_W-1:0] clr_ir;
    logic [NUM_CHAN*HALF_W-1:0] ir_view;
    wr_kind_t                   kind;

    assign kind = wr_kind(reg_idx);

    cop_dreg_lead_count #(.W(DATA_W), .CNT_W(LEAD_CNT_W)) u_lead (
        .value (reg_wdata),
        .count (lead_cnt)
    );

    cop_dreg_colour_unpack u_unpack (
        .fields  (reg_wdata[CPACK_W-1:0]),
        .ir_flat (clr_ir)
    );

    // intermediates 1..3 feed the colour packer
    generate
        for (genvar c = 0; c < int'(NUM_CHAN); c++) begin : g_view
            assign ir_view[c*HALF_W +: HALF_W] = regs_q[slot_at(S_IR_BASE, c + 1)][HALF_W-1:0];
        end
    endgenerate

    cop_dreg_colour_pack u_pack (
        .ir_flat    (ir_view),
        .packed_out (clr_packed)
    );

    always_comb begin
        for (int s = 0; s < int'(SLOT_COUNT); s++) regs_d[s] = regs_q[s];
        if (reg_we) begin
            unique case (kind)
                WK_SEXT: regs_d[reg_idx] = sext_half(reg_wdata[HALF_W-1:0]);
                WK_ZEXT: regs_d[reg_idx] = zext_half(reg_wdata[HALF_W-1:0]);
                WK_FIFO: begin
                    for (int k = 0; k < int'(XY_DEPTH) - 1; k++)
                        regs_d[slot_at(S_XY_BASE, k)] = regs_q[slot_at(S_XY_BASE, k + 1)];
                    regs_d[slot_at(S_XY_BASE, XY_DEPTH - 1)] = reg_wdata;
                end
                WK_COLOUR: begin
                    regs_d[S_CLR_IN] = {{(DATA_W-CPACK_W){1'b0}}, reg_wdata[CPACK_W-1:0]};
                    for (int c = 0; c < int'(NUM_CHAN); c++)
                        regs_d[slot_at(S_IR_BASE, c + 1)] = sext_half(clr_ir[c*HALF_W +: HALF_W]);
                end
                WK_LEAD: begin
                    regs_d[S_LEAD_IN] = reg_wdata;
                    regs_d[S_LEAD_CT] = word_t'(lead_cnt);
                end
                WK_RO: ;
                default: regs_d[reg_idx] = reg_wdata;
            endcase
        end else begin
            for (int k = 0; k < int'(NUM_ACC); k++)
                if (upd_acc_we[k]) regs_d[slot_at(S_ACC0, k)] = upd_acc_data[k*DATA_W +: DATA_W];
            for (int k = 0; k < int'(NUM_IR); k++)
                if (upd_ir_we[k]) regs_d[slot_at(S_IR_BASE, k)] = sext_half(upd_ir_data[k*HALF_W +: HALF_W]);
            if (upd_xy_push) begin
                for (int k = 0; k < int'(XY_DEPTH) - 1; k++)
                    regs_d[slot_at(S_XY_BASE, k)] = regs_q[slot_at(S_XY_BASE, k + 1)];
                regs_d[slot_at(S_XY_BASE, XY_DEPTH - 1)] = upd_xy_data;
            end
            if (upd_z_push) begin
                for (int k = 0; k < int'(Z_DEPTH) - 1; k++)
                    regs_d[slot_at(S_Z_BASE, k)] = regs_q[slot_at(S_Z_BASE, k + 1)];
                regs_d[slot_at(S_Z_BASE, Z_DEPTH - 1)] = zext_half(upd_z_data);
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < int'(SLOT_COUNT); s++) begin
            if (rst) regs_q[s] <= '0;
            else     regs_q[s] <= regs_d[s];
        end
    end

    always_comb begin
        case (reg_idx)
            S_XY_PUSH:            reg_rdata = regs_q[slot_at(S_XY_BASE, XY_DEPTH - 1)];
            S_CLR_IN, S_CLR_OUT:  reg_rdata = {{(DATA_W-CPACK_W){1'b0}}, clr_packed};
            default:              reg_rdata = regs_q[reg_idx];
        endcase
    end

    AST_ZEXT_ORDZ: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_idx == S_ORDZ) |=> (regs_q[S_ORDZ][DATA_W-1:HALF_W] == '0)); // R2

    AST_XY_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_idx == S_XY_PUSH) |=>
            (regs_q[12] == $past(regs_q[13])) && (regs_q[13] == $past(regs_q[14]))
            && (regs_q[14] == $past(reg_wdata))); // R3

    AST_CLR_IR_SCALE: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_idx == S_CLR_IN) |=>
            (regs_q[9][DATA_W-1:CFIELD_W+CSCALE_SH] == '0) && (regs_q[9][CSCALE_SH-1:0] == '0)); // R5

    AST_LEAD_RANGE: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_idx == S_LEAD_IN) |=>
            (regs_q[S_LEAD_CT] >= 1) && (regs_q[S_LEAD_CT] <= DATA_W)); // R7

    AST_LEAD_RO: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_idx == S_LEAD_CT) |=> $stable(regs_q[S_LEAD_CT])); // R8

    AST_SW_WINS: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_idx != S_ACC0 && upd_acc_we[0]) |=> $stable(regs_q[S_ACC0])); // R11

    AST_SW_WINS_Z: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_idx != 16 && reg_idx != 15 && upd_z_push) |=> $stable(regs_q[16])); // R11
endmodule

// File: tb/sim_cop_dreg_file.sv
module sim_cop_dreg_file;
    import cop_dreg_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                      rst = 1'b1;
    logic [IDX_W-1:0]          reg_idx;
    logic                      reg_we = 1'b0;
    logic [DATA_W-1:0]         reg_wdata = '0;
    logic [DATA_W-1:0]         reg_rdata;
    logic [NUM_ACC-1:0]        upd_acc_we = '0;
    logic [NUM_ACC*DATA_W-1:0] upd_acc_data = '0;
    logic [NUM_IR-1:0]         upd_ir_we = '0;
    logic [NUM_IR*HALF_W-1:0]  upd_ir_data = '0;
    logic                      upd_xy_push = 1'b0;
    logic [DATA_W-1:0]         upd_xy_data = '0;
    logic                      upd_z_push = 1'b0;
    logic [HALF_W-1:0]         upd_z_data = '0;

    logic [IDX_W-1:0] drv_idx = '0;
    logic [IDX_W-1:0] mon_idx = '0;
    logic             mon_sel = 1'b0;
    assign reg_idx = mon_sel ? mon_idx : drv_idx;

    cop_dreg_file u0 (
        .clk(clk), .rst(rst), .reg_idx(reg_idx), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .upd_acc_we(upd_acc_we), .upd_acc_data(upd_acc_data),
        .upd_ir_we(upd_ir_we), .upd_ir_data(upd_ir_data),
        .upd_xy_push(upd_xy_push), .upd_xy_data(upd_xy_data),
        .upd_z_push(upd_z_push), .upd_z_data(upd_z_data)
    );

    typedef struct {
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] val;
        string             tag;
    } exp_t;

    exp_t sb[$];
    exp_t cur;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    // monitor: pops one expectation per cycle and samples the read port
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                cur = sb.pop_front();
                mon_idx = cur.idx;
                mon_sel = 1'b1;
                #2;
                n_vec++;
                if (reg_rdata !== cur.val) begin
                    n_bad++;
                    $display("FAIL %s slot %0d actual %08h expected %08h",
                             cur.tag, cur.idx, reg_rdata, cur.val);
                end
                mon_sel = 1'b0;
            end
        end
    end

    task automatic expect_rd(input int idx, input logic [31:0] val, input string tag);
        sb.push_back('{idx: IDX_W'(idx), val: val, tag: tag});
    endtask

    task automatic drain();
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    task automatic sw_write(input int idx, input logic [31:0] data);
        drain();
        @(negedge clk);
        drv_idx   = IDX_W'(idx);
        reg_wdata = data;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12: every slot reads zero after reset
        for (int s = 0; s < 32; s++) expect_rd(s, 32'h0, "R12 reset");

        // R1
        sw_write(1, 32'h1234_8001);  expect_rd(1, 32'hFFFF_8001, "R1 vz0");
        sw_write(9, 32'h0000_7FFF);  expect_rd(9, 32'h0000_7FFF, "R1 ir1");
        sw_write(8, 32'hABCD_F000);  expect_rd(8, 32'hFFFF_F000, "R1 ir0");

        // R2
        sw_write(7, 32'hFFFF_8001);  expect_rd(7, 32'h0000_8001, "R2 ordz");
        sw_write(19, 32'h1234_ABCD); expect_rd(19, 32'h0000_ABCD, "R2 z3");

        // R9
        sw_write(0, 32'hDEAD_BEEF);  expect_rd(0, 32'hDEAD_BEEF, "R9 slot0");
        sw_write(6, 32'h0102_0304);  expect_rd(6, 32'h0102_0304, "R9 slot6");
        sw_write(23, 32'hCAFE_F00D); expect_rd(23, 32'hCAFE_F00D, "R9 slot23");
        sw_write(27, 32'h8000_0001); expect_rd(27, 32'h8000_0001, "R9 slot27");

        // R3 / R4
        sw_write(12, 32'h1111_2222);
        sw_write(13, 32'h3333_4444);
        sw_write(14, 32'h5555_6666);
        sw_write(15, 32'h7777_8888);
        expect_rd(12, 32'h3333_4444, "R3 xy0");
        expect_rd(13, 32'h5555_6666, "R3 xy1");
        expect_rd(14, 32'h7777_8888, "R3 xy2");
        expect_rd(15, 32'h7777_8888, "R4 mirror");

        // R5 / R6
        sw_write(28, 32'hFFFF_FFFF);
        expect_rd(9,  32'h0000_0F80, "R5 ir1");
        expect_rd(10, 32'h0000_0F80, "R5 ir2");
        expect_rd(11, 32'h0000_0F80, "R5 ir3");
        expect_rd(28, 32'h0000_7FFF, "R6 pack28");
        expect_rd(29, 32'h0000_7FFF, "R6 pack29");
        sw_write(28, 32'h0000_1234);
        expect_rd(9,  32'h0000_0A00, "R5 ir1 field");
        expect_rd(10, 32'h0000_0880, "R5 ir2 field");
        expect_rd(11, 32'h0000_0200, "R5 ir3 field");
        expect_rd(29, 32'h0000_1234, "R6 roundtrip");

        // R6 clamping and rounding toward zero
        sw_write(9,  32'hFFFF_FF80);
        sw_write(10, 32'h0000_7FFF);
        sw_write(11, 32'h0000_007F);
        expect_rd(28, 32'h0000_03E0, "R6 neg/high/trunc");
        sw_write(9,  32'h0000_0FFF);
        sw_write(10, 32'h0000_1000);
        sw_write(11, 32'hFFFF_8000);
        expect_rd(28, 32'h0000_03FF, "R6 clamp edges");

        // R7
        sw_write(30, 32'h0000_0000);
        expect_rd(30, 32'h0000_0000, "R7 store");
        expect_rd(31, 32'd32, "R7 all zero");
        sw_write(30, 32'hFFFF_FFFF); expect_rd(31, 32'd32, "R7 all ones");
        sw_write(30, 32'h8000_0000); expect_rd(31, 32'd1, "R7 single one");
        sw_write(30, 32'h7FFF_FFFF); expect_rd(31, 32'd1, "R7 single zero");
        sw_write(30, 32'h0001_0000); expect_rd(31, 32'd15, "R7 zeros");
        sw_write(30, 32'hF000_0000);
        expect_rd(31, 32'd4, "R7 ones");
        expect_rd(30, 32'hF000_0000, "R7 store neg");

        // R8
        sw_write(31, 32'h0000_0055); expect_rd(31, 32'd4, "R8 lead ro");
        sw_write(29, 32'h0000_FFFF);
        expect_rd(29, 32'h0000_03FF, "R8 colour ro");
        expect_rd(9,  32'h0000_0FFF, "R8 ir1 untouched");

        // R10 compute updates
        sw_write(16, 32'd1);
        sw_write(17, 32'd2);
        sw_write(18, 32'd3);
        sw_write(19, 32'd4);
        drain();
        @(negedge clk);
        upd_acc_we   = 4'hF;
        upd_acc_data = {32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0011};
        upd_ir_we    = 4'b0110;
        upd_ir_data  = {16'h0000, 16'h1234, 16'h8000, 16'h0000};
        upd_xy_push  = 1'b1;
        upd_xy_data  = 32'h0ABC_0DEF;
        upd_z_push   = 1'b1;
        upd_z_data   = 16'hBEEF;
        @(negedge clk);
        upd_acc_we = '0; upd_ir_we = '0; upd_xy_push = 1'b0; upd_z_push = 1'b0;
        expect_rd(24, 32'h0000_0011, "R10 acc0");
        expect_rd(25, 32'hFFFF_FFFF, "R10 acc1");
        expect_rd(26, 32'h7FFF_FFFF, "R10 acc2");
        expect_rd(27, 32'h8000_0000, "R10 acc3");
        expect_rd(8,  32'hFFFF_F000, "R10 ir0 kept");
        expect_rd(9,  32'hFFFF_8000, "R10 ir1 sext");
        expect_rd(10, 32'h0000_1234, "R10 ir2");
        expect_rd(11, 32'hFFFF_8000, "R10 ir3 kept");
        expect_rd(12, 32'h5555_6666, "R10 xy0");
        expect_rd(13, 32'h7777_8888, "R10 xy1");
        expect_rd(14, 32'h0ABC_0DEF, "R10 xy2");
        expect_rd(16, 32'd2, "R10 z0");
        expect_rd(17, 32'd3, "R10 z1");
        expect_rd(18, 32'd4, "R10 z2");
        expect_rd(19, 32'h0000_BEEF, "R10 z3");

        // R11 software write wins over same-cycle compute updates
        drain();
        @(negedge clk);
        drv_idx      = IDX_W'(24);
        reg_wdata    = 32'hA5A5_A5A5;
        reg_we       = 1'b1;
        upd_acc_we   = 4'b0010;
        upd_acc_data = {32'h0, 32'h0, 32'h1234_5678, 32'h0};
        @(negedge clk);
        reg_we = 1'b0; upd_acc_we = '0;
        expect_rd(24, 32'hA5A5_A5A5, "R11 sw slot");
        expect_rd(25, 32'hFFFF_FFFF, "R11 acc1 dropped");
        drain();
        @(negedge clk);
        drv_idx     = IDX_W'(0);
        reg_wdata   = 32'h0BAD_F00D;
        reg_we      = 1'b1;
        upd_xy_push = 1'b1;
        upd_xy_data = 32'h9999_9999;
        upd_z_push  = 1'b1;
        upd_z_data  = 16'h7777;
        @(negedge clk);
        reg_we = 1'b0; upd_xy_push = 1'b0; upd_z_push = 1'b0;
        expect_rd(0,  32'h0BAD_F00D, "R11 sw slot0");
        expect_rd(12, 32'h5555_6666, "R11 xy0 kept");
        expect_rd(14, 32'h0ABC_0DEF, "R11 xy2 kept");
        expect_rd(19, 32'h0000_BEEF, "R11 z3 kept");

        drain();
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule